// File: doc/BRIEF.md
# Full-Period Galois Sequence Generator

This block is a shift-register sequence generator whose register width is a parameter from 2 to 32 bits. It steps once per clock through every n-bit value, including all zeros, so its period is 2^n rather than the 2^n−1 of a plain maximal-length shift register. The feedback is in Galois (one-to-many) form: the top bit is fed back into bit 0 and XORed into each tapped stage on its way up the register. A zero-detect term on the lower n−1 bits is XORed into that feedback. This splices the all-zero state into the cycle, so it is no longer a lockup trap.

The tap pattern for each width is held in a constant function in the shared package. The function is indexed by the width parameter, and every width has a maximal-length polynomial. A width outside 2..32 stops elaboration. The only controls are the clock and an active-low asynchronous reset. The reset loads all zeros, which is a legal member of the sequence. The output is the register itself, with no logic after the flops.

Top module: `dbl_lfsr`

## Requirements
- R1: While rst_ni is low the state is all zeros, and it reaches all zeros at once when rst_ni falls, without waiting for a clock edge.
- R2: From the all-zero state the next state is the tap pattern below the top bit, shifted left one place, with bit 0 set. For the default width of 8 this is 0x71.
- R3: The state with only the top bit set steps to all zeros.
- R4: When the top bit is clear and the state is not all zeros, the next state is the state shifted left by one, with 0 entering bit 0.
- R5: When the top bit is set and any lower bit is set, the next state is the left-shifted state XORed with the zero-successor pattern of R2. For width 8 that pattern is 0x71, so 0x71 steps to 0xE2 and 0xE2 steps to 0xB5.
- R6: After reset the state returns to all zeros after exactly 2^n clocks and takes every n-bit value once on the way. For width 3 the sequence after zero is 3, 6, 7, 5, 1, 2, 4, 0.
- R7: The tap table gives binary 11 for width 2, binary 101 for width 3, 0x80000062 for width 32, binary 1100 for width 4 and 0xB8 for width 8. From zero, width 3 therefore steps to 0x3 and width 4 steps to 0x9.
- R8: state_o changes only on a rising clock edge or on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, loads all zeros |
| state_o | output | WIDTH | Current register contents |

## Verification
The bench aims at the two spliced transitions: zero to the tap pattern, and top-bit-only back to zero. If the zero-detect term were missing or on the wrong bits, the register would lock at zero or skip it, and the full-period walk would show a stuck state, a repeated value or a period of 2^n−1. Misplaced taps show up as wrong early values in the width-3 and width-8 sequences, and as duplicates within a period. A reset that waits for the clock shows up as a nonzero output in the gap between reset falling and the next edge.

// File: rtl/dbl_lfsr_pkg.sv
package dbl_lfsr_pkg;

  localparam int unsigned MinWidth = 2;
  localparam int unsigned MaxWidth = 32;

  // Top bit always set; other set bits k mean feedback is XORed into stage k+1.
  function automatic logic [31:0] tap_table(input int unsigned w);
    case (w)
      2:       return 32'h0000_0003;
      3:       return 32'h0000_0005;
      4:       return 32'h0000_000C;
      5:       return 32'h0000_0014;
      6:       return 32'h0000_0030;
      7:       return 32'h0000_0060;
      8:       return 32'h0000_00B8;
      9:       return 32'h0000_0110;
      10:      return 32'h0000_0240;
      11:      return 32'h0000_0500;
      12:      return 32'h0000_0829;
      13:      return 32'h0000_100D;
      14:      return 32'h0000_2015;
      15:      return 32'h0000_6000;
      16:      return 32'h0000_D008;
      17:      return 32'h0001_2000;
      18:      return 32'h0002_0400;
      19:      return 32'h0004_0023;
      20:      return 32'h0009_0000;
      21:      return 32'h0014_0000;
      22:      return 32'h0030_0000;
      23:      return 32'h0042_0000;
      24:      return 32'h00E1_0000;
      25:      return 32'h0120_0000;
      26:      return 32'h0200_0023;
      27:      return 32'h0400_0013;
      28:      return 32'h0900_0000;
      29:      return 32'h1400_0000;
      30:      return 32'h2000_0029;
      31:      return 32'h4800_0000;
      32:      return 32'h8000_0062;
      default: return 32'h0000_0000;
    endcase
  endfunction

  // Successor of the all-zero state: low taps shifted up, bit 0 set.
  function automatic logic [31:0] zero_successor(input int unsigned w);
    logic [63:0] low_mask;
    low_mask = (64'd1 << (w - 1)) - 64'd1;
    return 32'(((64'(tap_table(w)) & low_mask) << 1) | 64'd1);
  endfunction

endpackage

// File: rtl/dbl_zero_detect.sv
module dbl_zero_detect #(
  parameter int unsigned W = 8
) (
  input  logic [W-2:0] low_i,
  output logic         zero_o
);
  assign zero_o = ~|low_i;
endmodule

// File: rtl/dbl_galois_step.sv
module dbl_galois_step #(
  parameter int unsigned    W    = 8,
  parameter logic [W-1:0]   TAPS = '0
) (
  input  logic [W-1:0] state_i,
  input  logic         zero_low_i,
  output logic [W-1:0] next_o
);
  logic fb;

  assign fb        = state_i[W-1] ^ zero_low_i;
  assign next_o[0] = fb;

  for (genvar k = 1; k < W; k++) begin : g_stage
    if (TAPS[k-1]) begin : g_tap
      assign next_o[k] = state_i[k-1] ^ fb;
    end else begin : g_pass
      assign next_o[k] = state_i[k-1];
    end
  end
endmodule

// File: rtl/dbl_state_reg.sv
module dbl_state_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/dbl_lfsr.sv
module dbl_lfsr
  import dbl_lfsr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [WIDTH-1:0] state_o
);
  localparam logic [31:0]      TapAll = tap_table(WIDTH);
  localparam logic [WIDTH-1:0] Taps   = TapAll[WIDTH-1:0];

  if (WIDTH < MinWidth || WIDTH > MaxWidth) begin : g_bad_width
    $fatal(1, "dbl_lfsr: WIDTH must be within 2..32");
  end

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic             zero_low;

  dbl_zero_detect #(.W(WIDTH)) i_zero (
    .low_i  (state_q[WIDTH-2:0]),
    .zero_o (zero_low)
  );

  dbl_galois_step #(.W(WIDTH), .TAPS(Taps)) i_step (
    .state_i    (state_q),
    .zero_low_i (zero_low),
    .next_o     (state_d)
  );

  dbl_state_reg #(.W(WIDTH)) i_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  assign state_o = state_q;
endmodule

// File: rtl/dbl_lfsr_chk.sv
module dbl_lfsr_chk
  import dbl_lfsr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] state_o
);
  localparam logic [31:0]      SuccAll = zero_successor(WIDTH);
  localparam logic [WIDTH-1:0] Succ    = SuccAll[WIDTH-1:0];
  localparam logic [WIDTH-1:0] MsbOnly = {1'b1, {(WIDTH-1){1'b0}}};

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> state_o == '0);

  a_r2_zero_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == '0 |=> state_o == Succ);

  a_r3_zero_splice: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == MsbOnly |=> state_o == '0);

  a_r4_plain_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!state_o[WIDTH-1] && state_o != '0) |=>
      state_o == {$past(state_o[WIDTH-2:0]), 1'b0});

  a_r5_tap_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o[WIDTH-1] && |state_o[WIDTH-2:0]) |=>
      state_o == ({$past(state_o[WIDTH-2:0]), 1'b0} ^ Succ));

  a_r6_always_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> state_o != $past(state_o));
endmodule

bind dbl_lfsr dbl_lfsr_chk #(.WIDTH(WIDTH)) i_dbl_lfsr_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .state_o (state_o)
);

// File: tb/test_dbl_lfsr.sv
module test_dbl_lfsr;
  logic       clk   = 1'b0;
  logic       rst_n = 1'b1;
  logic [7:0] q8;
  logic [3:0] q4;
  logic [2:0] q3;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #5 clk = ~clk;

  dbl_lfsr #(.WIDTH(8)) i_dbl_lfsr    (.clk_i(clk), .rst_ni(rst_n), .state_o(q8));
  dbl_lfsr #(.WIDTH(4)) i_dbl_lfsr_w4 (.clk_i(clk), .rst_ni(rst_n), .state_o(q4));
  dbl_lfsr #(.WIDTH(3)) i_dbl_lfsr_w3 (.clk_i(clk), .rst_ni(rst_n), .state_o(q3));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] get_q(input int w);
    case (w)
      3:       return 32'(q3);
      4:       return 32'(q4);
      default: return 32'(q8);
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1: asynchronous clear, visible before any clock edge
  task automatic t_reset_state();
    #2 rst_n = 1'b0;
    #1;
    chk("R1 initial w8", 32'(q8), 32'h0);
    chk("R1 initial w4", 32'(q4), 32'h0);
    chk("R1 initial w3", 32'(q3), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) step();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk("R1 mid-run clear w8", 32'(q8), 32'h0);
    chk("R1 mid-run clear w3", 32'(q3), 32'h0);
    @(negedge clk);
    #1;
    chk("R1 held through edge", 32'(q8), 32'h0);
    rst_n = 1'b1;
  endtask

  // R2 R4 R5 on the default width
  task automatic t_w8_steps();
    do_reset();
    step(); chk("R2 zero successor w8", 32'(q8), 32'h71);
    step(); chk("R4 plain shift w8",    32'(q8), 32'hE2);
    step(); chk("R5 tapped shift w8",   32'(q8), 32'hB5);
  endtask

  // R8: no change between edges
  task automatic t_hold_between_edges();
    logic [7:0] held;
    step();
    held = q8;
    #3;
    chk("R8 stable between edges", 32'(q8), 32'(held));
  endtask

  // R7: tap table seen through the first step from zero
  task automatic t_taps();
    do_reset();
    step();
    chk("R7 w3 taps", 32'(q3), 32'h3);
    chk("R7 w4 taps", 32'(q4), 32'h9);
  endtask

  // R6 R3: explicit width-3 sequence
  task automatic t_w3_sequence();
    logic [2:0] exp_seq [8] = '{3'd3, 3'd6, 3'd7, 3'd5, 3'd1, 3'd2, 3'd4, 3'd0};
    do_reset();
    for (int i = 0; i < 8; i++) begin
      step();
      chk((i == 7) ? "R3 w3 top-only to zero" : "R6 w3 sequence", 32'(q3), 32'(exp_seq[i]));
    end
  endtask

  // R6: full period and uniqueness
  task automatic t_period(input int w);
    logic [255:0] seen;
    int           n;
    int           dups;
    int           count;
    logic [31:0]  v;
    seen  = '0;
    dups  = 0;
    count = 0;
    n     = 1 << w;
    do_reset();
    for (int i = 0; i < n; i++) begin
      step();
      v = get_q(w);
      if (seen[v[7:0]]) dups++;
      else count++;
      seen[v[7:0]] = 1'b1;
    end
    chk($sformatf("R6 w%0d no repeat", w),      32'(dups),  32'h0);
    chk($sformatf("R6 w%0d all values", w),     32'(count), 32'(n));
    chk($sformatf("R6 w%0d back to zero", w),   v,          32'h0);
  endtask

  // R3 R4 R5: every transition of a full width-8 period against the rules
  task automatic t_rules_w8();
    logic [7:0] prev;
    logic [7:0] exp;
    int         bad_shift;
    int         bad_tap;
    int         bad_splice;
    bad_shift  = 0;
    bad_tap    = 0;
    bad_splice = 0;
    do_reset();
    step();
    for (int i = 0; i < 256; i++) begin
      prev = q8;
      step();
      if (prev == 8'h80) begin
        if (q8 != 8'h00) bad_splice++;
      end else if (prev == 8'h00) begin
        if (q8 != 8'h71) bad_splice++;
      end else if (!prev[7]) begin
        exp = {prev[6:0], 1'b0};
        if (q8 != exp) bad_shift++;
      end else begin
        exp = {prev[6:0], 1'b0} ^ 8'h71;
        if (q8 != exp) bad_tap++;
      end
    end
    chk("R3 splice transitions w8", 32'(bad_splice), 32'h0);
    chk("R4 shift transitions w8",  32'(bad_shift),  32'h0);
    chk("R5 tap transitions w8",    32'(bad_tap),    32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R6: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_w8_steps();
    t_hold_between_edges();
    t_taps();
    t_w3_sequence();
    t_period(3);
    t_period(4);
    t_period(8);
    t_rules_w8();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule